// File: doc/BRIEF.md
# Fibonacci Sequence Engine with Selectable Loop Schedule

This block is a small controller-plus-datapath engine that produces a Fibonacci-style value. A one-cycle start pulse captures a count N from the input. The block clears the lower accumulator to 0 and sets the upper accumulator to 1. It then repeats an update step while the count is nonzero:

- the upper accumulator takes the sum of both accumulators;
- the lower accumulator takes the new upper value minus the old lower value, which equals the previous upper value;
- the count drops by one.

When the count reaches zero, the upper accumulator is copied to the result port and a one-cycle done flag is raised.

The compile-time parameter `TWO_STEP` selects one of two loop schedules.

- **Single-cycle schedule (`TWO_STEP = 0`).** Each iteration completes in one clock. A dedicated adder feeds a dedicated subtractor in a chain.
- **Shared schedule (`TWO_STEP = 1`).** Each iteration is split over two clocks. One add/subtract unit is used in both clocks, with its mode taken from the sub-step state.

Both schedules give the same numeric result. Only the latency and the amount of arithmetic hardware differ.

The controller has five states:

- `ST_IDLE`: waits for start.
- `ST_INIT`: tests whether the count is zero.
- `ST_STEP`: a full iteration, or the add sub-step in the shared schedule.
- `ST_SUBT`: the subtract sub-step; used only in the shared schedule.
- `ST_FINISH`: captures the result.

Its transitions are:

- `ST_IDLE` to `ST_INIT` on start.
- `ST_INIT` to `ST_FINISH` when the count is zero.
- `ST_INIT` to `ST_STEP` when the count is nonzero.
- In the single-cycle schedule, `ST_STEP` returns to `ST_STEP` while the count is above one, and moves to `ST_FINISH` when the count is one.
- In the shared schedule, `ST_STEP` always moves to `ST_SUBT`. `ST_SUBT` moves back to `ST_STEP` while the count is above one, and to `ST_FINISH` when it is one.
- `ST_FINISH` returns to `ST_IDLE`.

Top module: `fib_engine`

## Requirements
- R1: While reset is asserted and in the first cycle after it is released, `done` is 0 and `result` is 0.
- R2: A `start` sampled high in idle captures `n_in` as the count and sets the accumulators to 0 (lower) and 1 (upper). After completion, `result` equals the (N+1)-th Fibonacci number (1, 1, 2, 3, 5, ...), reduced modulo 2^WIDTH.
- R3: One iteration sets the upper accumulator to lower plus upper, sets the lower accumulator to the old upper, and decrements the count by one. The result is the same under both schedules.
- R4: With N = 0 no iteration runs, `result` is 1, and `done` rises on the 3rd rising edge, counting the edge that samples `start` as the first.
- R5: With `TWO_STEP = 0`, `done` rises on rising edge N+3, counting the start-sampling edge as edge 1.
- R6: With `TWO_STEP = 1`, `done` rises on rising edge 2N+3, counted the same way.
- R7: `done` is high for exactly one cycle per accepted start.
- R8: A `start` pulse that arrives while a computation is running is ignored. It produces no extra `done`, and it leaves the result of the running computation unchanged.
- R9: `result` changes only in the cycle in which `done` rises, and otherwise holds its value.
- R10: All arithmetic wraps modulo 2^WIDTH; large N returns the truncated value.
- R11: In the shared schedule, the single unit adds in the sub-step that writes the upper accumulator and subtracts in the sub-step that writes the lower accumulator. The two accumulators are never written in the same cycle.
- R12: The count is never decremented at zero. The loop exits once the count reaches zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | One-cycle request; honoured only in idle |
| n_in | input | WIDTH | Iteration count, sampled with an accepted start |
| result | output | WIDTH | Final upper accumulator, held until the next completion |
| done | output | 1 | One-cycle pulse marking a new valid result |

## Verification
The assertions take for granted that reset is held low across the first clock edge. They also assume that `n_in` matters only in the cycle where `start` is accepted, so that they can compare the loaded count against the sampled input. The stimulus drives `start` as a single-cycle pulse, changes `n_in` only at falling edges, and puts a garbage value on `n_in` after each pulse to show the count was captured. The only start issued during a busy interval is the deliberate one that checks that such starts are dropped. Both schedules run side by side from the same stimulus, and the bench compares each result and each latency against a software model.

// File: rtl/fib_pkg.sv
package fib_pkg;

    typedef enum logic [2:0] {
        ST_IDLE   = 3'd0,
        ST_INIT   = 3'd1,
        ST_STEP   = 3'd2,
        ST_SUBT   = 3'd3,
        ST_FINISH = 3'd4
    } fib_state_e;

    typedef struct packed {
        logic load;     // capture count, clear accumulators
        logic upd_f1;   // write upper accumulator
        logic upd_f0;   // write lower accumulator
        logic dec_n;    // decrement count
        logic alu_sub;  // shared unit mode: 1 = subtract
        logic capture;  // copy upper accumulator to result
    } fib_ctl_t;

endpackage

// File: rtl/fib_alu.sv
module fib_alu #(
    parameter int WIDTH = 16
) (
    input  logic [WIDTH-1:0] a,
    input  logic [WIDTH-1:0] b,
    input  logic             sub,
    output logic [WIDTH-1:0] y
);

    always_comb begin
        if (sub) y = a - b;
        else     y = a + b;
    end

endmodule

// File: rtl/fib_datapath.sv
module fib_datapath
    import fib_pkg::*;
#(
    parameter int WIDTH    = 16,
    parameter int TWO_STEP = 0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] n_in,
    input  fib_ctl_t         ctl,
    output logic             n_zero,
    output logic             n_one,
    output logic [WIDTH-1:0] result
);

    localparam logic [WIDTH-1:0] ONE  = WIDTH'(1);
    localparam logic [WIDTH-1:0] ZERO = '0;

    logic [WIDTH-1:0] n_q;
    logic [WIDTH-1:0] f0_q;
    logic [WIDTH-1:0] f1_q;
    logic [WIDTH-1:0] res_q;
    logic [WIDTH-1:0] f0_nxt;
    logic [WIDTH-1:0] f1_nxt;

    generate
        if (TWO_STEP == 0) begin : g_parallel
            logic [WIDTH-1:0] sum;
            logic [WIDTH-1:0] diff;
            // dedicated adder chained into dedicated subtractor
            fib_alu #(.WIDTH(WIDTH)) u_add (
                .a(f0_q), .b(f1_q), .sub(1'b0), .y(sum)
            );
            fib_alu #(.WIDTH(WIDTH)) u_sub (
                .a(sum), .b(f0_q), .sub(1'b1), .y(diff)
            );
            assign f1_nxt = sum;
            assign f0_nxt = diff;

            // R3
            iter_par_chk: assert property (@(posedge clk) disable iff (!rst_n)
                (ctl.upd_f0 && ctl.upd_f1) |=>
                    (f0_q == $past(f1_q) && f1_q == $past(f0_q) + $past(f1_q)));
        end else begin : g_shared
            logic [WIDTH-1:0] opa;
            logic [WIDTH-1:0] opb;
            logic [WIDTH-1:0] alu_y;
            always_comb begin
                if (ctl.alu_sub) begin
                    opa = f1_q;
                    opb = f0_q;
                end else begin
                    opa = f0_q;
                    opb = f1_q;
                end
            end
            fib_alu #(.WIDTH(WIDTH)) u_shared (
                .a(opa), .b(opb), .sub(ctl.alu_sub), .y(alu_y)
            );
            assign f1_nxt = alu_y;
            assign f0_nxt = alu_y;

            // R11
            one_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
                !(ctl.upd_f0 && ctl.upd_f1));
            // R11
            add_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
                ctl.upd_f1 |=> f1_q == $past(f0_q) + $past(f1_q));
            // R3
            sub_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
                ctl.upd_f0 |=> f0_q == $past(f1_q) - $past(f0_q));
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            n_q   <= ZERO;
            f0_q  <= ZERO;
            f1_q  <= ZERO;
            res_q <= ZERO;
        end else begin
            if (ctl.load) begin
                n_q  <= n_in;
                f0_q <= ZERO;
                f1_q <= ONE;
            end else begin
                if (ctl.upd_f1) f1_q <= f1_nxt;
                if (ctl.upd_f0) f0_q <= f0_nxt;
                if (ctl.dec_n)  n_q  <= n_q - ONE;
            end
            if (ctl.capture) res_q <= f1_q;
        end
    end

    assign n_zero = (n_q == ZERO);
    assign n_one  = (n_q == ONE);
    assign result = res_q;

    // R12
    dec_no_underflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ctl.dec_n |-> !n_zero);
    // R2
    load_init_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ctl.load |=> (f0_q == ZERO && f1_q == ONE && n_q == $past(n_in)));
    // R9
    res_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ctl.capture |=> $stable(res_q));

endmodule

// File: rtl/fib_ctrl.sv
module fib_ctrl
    import fib_pkg::*;
#(
    parameter int TWO_STEP = 0
) (
    input  logic     clk,
    input  logic     rst_n,
    input  logic     start,
    input  logic     n_zero,
    input  logic     n_one,
    output fib_ctl_t ctl,
    output logic     done
);

    localparam bit SHARED = (TWO_STEP != 0);

    fib_state_e state_q;
    fib_state_e state_d;
    logic       done_q;

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (start) state_d = ST_INIT;
            ST_INIT:   state_d = n_zero ? ST_FINISH : ST_STEP;
            ST_STEP: begin
                if (SHARED)     state_d = ST_SUBT;
                else if (n_one) state_d = ST_FINISH;
                else            state_d = ST_STEP;
            end
            ST_SUBT:   state_d = n_one ? ST_FINISH : ST_STEP;
            ST_FINISH: state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // datapath controls
    always_comb begin
        ctl = '0;
        unique case (state_q)
            ST_IDLE:   ctl.load = start;
            ST_INIT:   ;
            ST_STEP: begin
                ctl.upd_f1 = 1'b1;
                if (!SHARED) begin
                    ctl.upd_f0 = 1'b1;
                    ctl.dec_n  = 1'b1;
                end
            end
            ST_SUBT: begin
                ctl.upd_f0  = 1'b1;
                ctl.dec_n   = 1'b1;
                ctl.alu_sub = 1'b1;
            end
            ST_FINISH: ctl.capture = 1'b1;
            default:   ;
        endcase
    end

    // registered completion flag
    always_ff @(posedge clk) begin
        if (!rst_n) done_q <= 1'b0;
        else        done_q <= (state_q == ST_FINISH);
    end

    assign done = done_q;

    // R7
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_q |=> !done_q);
    // R8
    init_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_INIT) |-> ($past(state_q) == ST_IDLE));
    // R4
    zero_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_INIT && n_zero) |=> (state_q == ST_FINISH));
    // R11
    subt_shared_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_STEP && SHARED) |=> (state_q == ST_SUBT));

endmodule

// File: rtl/fib_engine.sv
module fib_engine
    import fib_pkg::*;
#(
    parameter int WIDTH    = 16,
    parameter int TWO_STEP = 0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [WIDTH-1:0] n_in,
    output logic [WIDTH-1:0] result,
    output logic             done
);

    fib_ctl_t ctl;
    logic     n_zero;
    logic     n_one;

    fib_ctrl #(.TWO_STEP(TWO_STEP)) u_ctrl (
        .clk    (clk),
        .rst_n  (rst_n),
        .start  (start),
        .n_zero (n_zero),
        .n_one  (n_one),
        .ctl    (ctl),
        .done   (done)
    );

    fib_datapath #(.WIDTH(WIDTH), .TWO_STEP(TWO_STEP)) u_dp (
        .clk    (clk),
        .rst_n  (rst_n),
        .n_in   (n_in),
        .ctl    (ctl),
        .n_zero (n_zero),
        .n_one  (n_one),
        .result (result)
    );

    // R9
    result_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(result) |-> done);

endmodule

// File: tb/test_fib_engine.sv
module test_fib_engine;

    localparam int W = 16;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         start = 1'b0;
    logic [W-1:0] n_in = '0;
    logic [W-1:0] res_a;
    logic [W-1:0] res_b;
    logic         done_a;
    logic         done_b;

    always #10 clk = ~clk;

    fib_engine #(.WIDTH(W), .TWO_STEP(0)) i_fib_engine (
        .clk(clk), .rst_n(rst_n), .start(start), .n_in(n_in),
        .result(res_a), .done(done_a)
    );

    fib_engine #(.WIDTH(W), .TWO_STEP(1)) i_fib_engine_shared (
        .clk(clk), .rst_n(rst_n), .start(start), .n_in(n_in),
        .result(res_b), .done(done_b)
    );

    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    logic [W-1:0] qa_res[$];
    int           qa_cyc[$];
    string        qa_tag[$];
    logic [W-1:0] qb_res[$];
    int           qb_cyc[$];
    string        qb_tag[$];

    function automatic logic [W-1:0] ref_fib(int n);
        logic [W-1:0] a = '0;
        logic [W-1:0] b = W'(1);
        logic [W-1:0] t;
        for (int i = 0; i < n; i++) begin
            t = a + b;
            a = b;
            b = t;
        end
        return b;
    endfunction

    task automatic chk(string tag, string what, longint act, longint exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    // monitor: single-cycle schedule
    logic [W-1:0] ra;
    int           ca;
    string        ta;
    bit           pend_a = 1'b0;
    always @(negedge clk) begin
        if (pend_a) begin
            chk("R7", "single done width", done_a, 0);
            pend_a = 1'b0;
        end
        if (rst_n && done_a) begin
            pend_a = 1'b1;
            if (qa_res.size() == 0) begin
                chk("R8", "single unexpected done", 1, 0);
            end else begin
                ra = qa_res.pop_front();
                ca = qa_cyc.pop_front();
                ta = qa_tag.pop_front();
                chk({ta, " R3"}, "single result", res_a, ra);
                chk("R5", "single latency", cyc, ca);
            end
        end
    end

    // monitor: shared schedule
    logic [W-1:0] rb;
    int           cb;
    string        tb;
    bit           pend_b = 1'b0;
    always @(negedge clk) begin
        if (pend_b) begin
            chk("R7", "shared done width", done_b, 0);
            pend_b = 1'b0;
        end
        if (rst_n && done_b) begin
            pend_b = 1'b1;
            if (qb_res.size() == 0) begin
                chk("R8", "shared unexpected done", 1, 0);
            end else begin
                rb = qb_res.pop_front();
                cb = qb_cyc.pop_front();
                tb = qb_tag.pop_front();
                chk({tb, " R3 R11"}, "shared result", res_b, rb);
                chk("R6", "shared latency", cyc, cb);
            end
        end
    end

    task automatic push_exp(int n, string tag);
        logic [W-1:0] e;
        e = ref_fib(n);
        qa_res.push_back(e);
        qa_cyc.push_back(cyc + n + 3);
        qa_tag.push_back(tag);
        qb_res.push_back(e);
        qb_cyc.push_back(cyc + 2 * n + 3);
        qb_tag.push_back(tag);
    endtask

    task automatic pulse(int n);
        start = 1'b1;
        n_in  = W'(n);
        @(negedge clk);
        start = 1'b0;
        n_in  = '1;
    endtask

    task automatic drain_and_hold(int n);
        logic [W-1:0] e;
        e = ref_fib(n);
        while (qa_res.size() != 0 || qb_res.size() != 0) @(negedge clk);
        repeat (4) @(negedge clk);
        chk("R9", "single result held", res_a, e);
        chk("R9", "shared result held", res_b, e);
    endtask

    task automatic run(int n, string tag);
        @(negedge clk);
        push_exp(n, tag);
        pulse(n);
        drain_and_hold(n);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        chk("R1", "single done in reset", done_a, 0);
        chk("R1", "single result in reset", res_a, 0);
        chk("R1", "shared done in reset", done_b, 0);
        chk("R1", "shared result in reset", res_b, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1", "single done after reset", done_a, 0);
        chk("R1", "shared result after reset", res_b, 0);

        run(0, "R4 R12");
        run(1, "R2");
        run(2, "R2");
        run(5, "R2 R12");
        run(10, "R2");

        // R8: second start while busy is dropped
        @(negedge clk);
        push_exp(6, "R8");
        pulse(6);
        @(negedge clk);
        pulse(3);
        drain_and_hold(6);

        // back-to-back requests
        run(7, "R3");
        run(3, "R3");

        // R10: wrap modulo 2^16
        run(24, "R10");
        run(40, "R10");
        chk("R10", "wrapped value for 40", res_a, ref_fib(40));

        chk("R8", "single queue empty", qa_res.size(), 0);
        chk("R8", "shared queue empty", qb_res.size(), 0);

        if (!finished) begin
            finished = 1'b1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            errors++;
            checks++;
            $display("FAIL R5 watchdog: actual=hung expected=done");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule